// File: doc/BRIEF.md
# Disk Drive Controller Register Interface

This block is the host-facing register file of a disk-drive controller. It sits on a 32-bit bus with word addresses and a four-bit byte-lane enable. Three addresses are decoded as actions rather than plain storage. A write to the command/status word posts a command and raises a level interrupt to the host. A write to the buffer-manager control word acknowledges that interrupt, and can also clear the interrupt-mask bit or the mechanism-interrupt flag. A write to the hard-reset address that carries the right key forces the status word to its reset-only value. All remaining addresses are plain storage that honours the byte enables.

Reads are registered. A read request returns the word held before the request's clock edge one cycle later, together with a valid strobe. The drive mechanics, data buffers, real-time clock and error correction are outside this block. Only the status side effects that commands cause are modelled here.

Word map: 0 is command/status, 1 is buffer-manager control, 2 is hard reset (reads as zero), and 3 up to NUM_REGS-1 are plain storage.

Top module: `dskctl_regs`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 0, host_irq is 0, key_err is 0 and rd_valid is 0.
- R2: A read with rd_en high at an edge gives rd_valid high one cycle later, with rdata equal to the word at addr before that edge. A read of word 2 returns 0. A cycle without rd_en gives rd_valid low in the next cycle.
- R3: Any write to word 0, whatever its data or byte enables, sets status bit 25 (mechanism interrupt) and drives host_irq high from the next cycle. Other status bits are left as they were, except as R4 states.
- R4: A write of 0x00090000 (clear-reset command) to word 0 also clears status bit 22 (reset state) in the same update.
- R5: Any write to word 1 drives host_irq low from the next cycle.
- R6: A write of exactly 0x10000000 to word 1 clears bit 29 (interrupt mask) of the buffer-manager word and keeps its other bits. The value itself is not stored.
- R7: A write of exactly 0x01000000 to word 1 clears status bit 25 and leaves the buffer-manager word unchanged.
- R8: Any other write to word 1 is stored into the buffer-manager word, byte lane i taking wdata[8i+7:8i] only where byte_en[i] is 1.
- R9: A write of 0xAAAA0000 to word 2 loads the status word with 0x00400000 (only bit 22 set). host_irq is not changed.
- R10: A write of any other value to word 2 leaves the status word unchanged and sets key_err. key_err stays high until reset.
- R11: A write to a plain word (3 up to NUM_REGS-1) updates byte lane i to wdata[8i+7:8i] only where byte_en[i] is 1.
- R12: host_irq is a level. Once high, it stays high through idle cycles and writes to other words, until a write to word 1 or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| byte_en | input | 4 | Byte-lane write enables |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| host_irq | output | 1 | Level interrupt to the host |
| key_err | output | 1 | Sticky flag: hard-reset write with a wrong key |

## Verification
Every write takes effect at the edge that samples it. host_irq and key_err are therefore due one cycle after the write, and the register contents can be read from the next cycle. Read data arrives exactly one cycle after the request. The bench drives inputs at falling edges and samples the interrupt and error flags at the falling edge that follows the write. Each read pushes its expected word into a queue, and a monitor pops and compares one entry on every falling edge that shows rd_valid. A missing or extra response therefore shows as a queue mismatch.

// File: rtl/dskctl_pkg.sv
// Shared constants for the disk controller register interface.
// Assumes a 32-bit data word split into four byte lanes.
package dskctl_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    // Word indices with side effects; plain storage starts after them.
    localparam int IDX_CMD   = 0;
    localparam int IDX_BM    = 1;
    localparam int IDX_HRST  = 2;
    localparam int IDX_PLAIN = 3;

    // Command and control values decoded by the block.
    localparam logic [WORD_W-1:0] CMD_CLEAR_RESET = 32'h0009_0000;
    localparam logic [WORD_W-1:0] BM_RESET_REQ    = 32'h1000_0000;
    localparam logic [WORD_W-1:0] BM_MECH_ACK     = 32'h0100_0000;
    localparam logic [WORD_W-1:0] HARD_RESET_KEY  = 32'hAAAA_0000;
    localparam logic [WORD_W-1:0] STAT_RESET_ONLY = 32'h0040_0000;

    // Bit positions used by the side effects.
    localparam int ST_MECH_IRQ = 25;
    localparam int ST_RESET    = 22;
    localparam int BM_INTMASK  = 29;

    typedef struct packed {
        logic cmd;
        logic bm;
        logic hrst;
    } wr_strobe_t;

    // Byte-lane merge of new data into an old word.
    function automatic logic [WORD_W-1:0] merge_lanes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/dskctl_decode.sv
// Address decode: turns a write request into one strobe per target.
// Assumes NUM_REGS > IDX_PLAIN; addresses at or above NUM_REGS are dropped.
module dskctl_decode
    import dskctl_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    output wr_strobe_t          strobe,
    output logic [NUM_REGS-1:0] plain_we
);
    // Decode the special words.
    always_comb begin
        strobe.cmd  = wr_en && (int'(addr) == IDX_CMD);
        strobe.bm   = wr_en && (int'(addr) == IDX_BM);
        strobe.hrst = wr_en && (int'(addr) == IDX_HRST);
    end

    // One write enable per plain word.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            plain_we[i] = wr_en && (int'(addr) == i) && (i >= IDX_PLAIN);
        end
    end

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe.cmd, strobe.bm, strobe.hrst, plain_we}));
endmodule

// File: rtl/dskctl_status.sv
// Command/status word, host interrupt level and key-error flag.
// Assumes at most one strobe per cycle (single write port).
module dskctl_status
    import dskctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        strobe,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status_q,
    output logic              irq_q,
    output logic              key_err_q
);
    logic key_ok;
    assign key_ok = (wdata == HARD_RESET_KEY);

    // Status word: commands set flags, hard reset overwrites, ack clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (strobe.hrst && key_ok) begin
            status_q <= STAT_RESET_ONLY;
        end else if (strobe.cmd) begin
            status_q[ST_MECH_IRQ] <= 1'b1;
            if (wdata == CMD_CLEAR_RESET) status_q[ST_RESET] <= 1'b0;
        end else if (strobe.bm && (wdata == BM_MECH_ACK)) begin
            status_q[ST_MECH_IRQ] <= 1'b0;
        end
    end

    // Interrupt level: raised by any command, dropped by any control write.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (strobe.cmd) irq_q <= 1'b1;
        else if (strobe.bm)  irq_q <= 1'b0;
    end

    // Sticky flag for a hard-reset write with the wrong key.
    always_ff @(posedge clk) begin
        if (!rst_n)                       key_err_q <= 1'b0;
        else if (strobe.hrst && !key_ok)  key_err_q <= 1'b1;
    end

    // R3
    cmd_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.cmd |=> irq_q && status_q[ST_MECH_IRQ]);
    // R4
    clear_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.cmd && wdata == CMD_CLEAR_RESET |=> !status_q[ST_RESET]);
    // R5
    bm_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.bm |=> !irq_q);
    // R7
    mech_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.bm && wdata == BM_MECH_ACK |=> !status_q[ST_MECH_IRQ]);
    // R9
    hard_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.hrst && key_ok |=> status_q == STAT_RESET_ONLY && $stable(irq_q));
    // R10
    bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.hrst && !key_ok |=> $stable(status_q) && key_err_q);
    // R10
    key_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_err_q |=> key_err_q);
    // R12
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !strobe.bm |=> irq_q);
endmodule

// File: rtl/dskctl_bmctl.sv
// Buffer-manager control word: two decoded values, otherwise masked storage.
// Assumes the interrupt side effects of these writes live in dskctl_status.
module dskctl_bmctl
    import dskctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  byte_en,
    output logic [WORD_W-1:0] bm_q
);
    // Control word update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bm_q <= '0;
        end else if (we) begin
            if (wdata == BM_RESET_REQ)     bm_q[BM_INTMASK] <= 1'b0;
            else if (wdata != BM_MECH_ACK) bm_q <= merge_lanes(bm_q, wdata, byte_en);
        end
    end

    // R6
    bm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && wdata == BM_RESET_REQ |=>
            !bm_q[BM_INTMASK] && $stable(bm_q[BM_INTMASK-1:0]) && $stable(bm_q[WORD_W-1:BM_INTMASK+1]));
    // R7
    bm_ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && wdata == BM_MECH_ACK |=> $stable(bm_q));
endmodule

// File: rtl/dskctl_word.sv
// One plain storage word with byte-lane write enables.
module dskctl_word
    import dskctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  byte_en,
    output logic [WORD_W-1:0] q
);
    // Masked storage update.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= merge_lanes(q, wdata, byte_en);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R11
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we && !byte_en[l] |=> $stable(q[l*8 +: 8]));
        // R11
        lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we && byte_en[l] |=> q[l*8 +: 8] == $past(wdata[l*8 +: 8]));
    end
endmodule

// File: rtl/dskctl_regs.sv
// Top of the disk controller register interface: decode, status and control
// words, plain storage and a registered read port with one cycle latency.
// Assumes one access port; a read sees the state from before its own edge.
module dskctl_regs
    import dskctl_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        byte_en,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    output logic              host_irq,
    output logic              key_err
);
    wr_strobe_t          strobe;
    logic [NUM_REGS-1:0] plain_we;
    logic [WORD_W-1:0]   status_q;
    logic [WORD_W-1:0]   bm_q;
    logic [WORD_W-1:0]   plain_q [NUM_REGS];
    logic [WORD_W-1:0]   rd_word;

    dskctl_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .strobe(strobe), .plain_we(plain_we)
    );

    dskctl_status u_status (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .wdata(wdata),
        .status_q(status_q), .irq_q(host_irq), .key_err_q(key_err)
    );

    dskctl_bmctl u_bmctl (
        .clk(clk), .rst_n(rst_n), .we(strobe.bm), .wdata(wdata),
        .byte_en(byte_en), .bm_q(bm_q)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_plain
        if (i >= IDX_PLAIN) begin : g_word
            dskctl_word u_word (
                .clk(clk), .rst_n(rst_n), .we(plain_we[i]), .wdata(wdata),
                .byte_en(byte_en), .q(plain_q[i])
            );
        end else begin : g_none
            logic unused_we;
            assign unused_we  = plain_we[i];
            assign plain_q[i] = '0;
        end
    end

    // Read mux over the current register state.
    always_comb begin
        if (int'(addr) == IDX_CMD)        rd_word = status_q;
        else if (int'(addr) == IDX_BM)    rd_word = bm_q;
        else if (int'(addr) >= NUM_REGS)  rd_word = '0;
        else                              rd_word = plain_q[addr];
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_word;
        end
    end

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R2
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: tb/dskctl_regs_test.sv
`timescale 1ns/1ps
module dskctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  byte_en = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        host_irq;
    logic        key_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    dskctl_regs #(.NUM_REGS(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .byte_en(byte_en), .rdata(rdata), .rd_valid(rd_valid),
        .host_irq(host_irq), .key_err(key_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver tasks: entered at a falling edge, leave at the next one.
    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; addr = 3'(a); wdata = d; byte_en = be;
        @(negedge clk);
        wr_en = 1'b0; byte_en = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = 3'(a);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: one response per falling edge showing rd_valid.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected response", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        chk("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 host_irq after reset", 32'(host_irq), 32'd0);
        chk("R1 key_err after reset", 32'(key_err), 32'd0);
        chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        for (int i = 0; i < 8; i++) rd(i, 32'h0, "R1 register zero after reset");

        // R3 any command, even with no byte enables
        wr(0, 32'h0000_0000, 4'b0000);
        chk("R3 irq after no-op command", 32'(host_irq), 32'd1);
        rd(0, 32'h0200_0000, "R3 status after no-op command");

        // R5 / R8 ordinary control write
        wr(1, 32'h1234_56FF, 4'b0001);
        chk("R5 irq dropped by control write", 32'(host_irq), 32'd0);
        rd(1, 32'h0000_00FF, "R8 masked control storage");

        // R9 hard reset with key
        wr(2, 32'hAAAA_0000, 4'b1111);
        chk("R9 irq untouched by hard reset", 32'(host_irq), 32'd0);
        rd(0, 32'h0040_0000, "R9 status after hard reset");

        // R3 keeps other bits, R12 level holds
        wr(0, 32'h0001_0001, 4'b1111);
        rd(0, 32'h0240_0000, "R3 seek command keeps reset bit");
        idle(5);
        wr(4, 32'h0000_0001, 4'b1111);
        chk("R12 irq held through idle and plain write", 32'(host_irq), 32'd1);

        // R4 clear-reset command
        wr(0, 32'h0009_0000, 4'b1111);
        rd(0, 32'h0200_0000, "R4 clear-reset clears bit 22");

        // R7 mechanism acknowledge
        wr(1, 32'h0100_0000, 4'b1111);
        chk("R7 irq dropped by acknowledge", 32'(host_irq), 32'd0);
        rd(0, 32'h0000_0000, "R7 status bit 25 cleared");
        rd(1, 32'h0000_00FF, "R7 control word unchanged");

        // R8 then R6
        wr(1, 32'h3000_0000, 4'b1111);
        rd(1, 32'h3000_0000, "R8 full control write");
        wr(1, 32'h1000_0000, 4'b1111);
        rd(1, 32'h1000_0000, "R6 mask bit 29 cleared, bit 28 kept");

        // R10 wrong key
        wr(0, 32'h000C_0000, 4'b1111);
        wr(2, 32'h1234_5678, 4'b1111);
        chk("R10 key_err set", 32'(key_err), 32'd1);
        rd(0, 32'h0200_0000, "R10 status unchanged by wrong key");
        wr(2, 32'hAAAA_0000, 4'b1111);
        chk("R10 key_err sticky", 32'(key_err), 32'd1);
        rd(0, 32'h0040_0000, "R9 status after second hard reset");

        // R11 plain storage lanes
        wr(3, 32'hDEAD_BEEF, 4'b1111);
        wr(3, 32'h1122_3344, 4'b0101);
        wr(7, 32'hA5A5_A5A5, 4'b1000);
        rd(3, 32'hDE22_BE44, "R11 partial lane write");
        rd(7, 32'hA500_0000, "R11 top lane only");
        rd(4, 32'h0000_0001, "R11 full write");
        // R2 hard-reset word reads zero
        rd(2, 32'h0000_0000, "R2 hard-reset word reads zero");

        // R1 mid-run reset
        wr(0, 32'h001B_0000, 4'b1111);
        chk("R3 irq before reset", 32'(host_irq), 32'd1);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        chk("R1 irq cleared by reset", 32'(host_irq), 32'd0);
        chk("R1 key_err cleared by reset", 32'(key_err), 32'd0);
        rd(0, 32'h0, "R1 status zero after reset");
        rd(1, 32'h0, "R1 control zero after reset");
        rd(3, 32'h0, "R1 plain zero after reset");
        idle(3);
        chk("R2 all responses received", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule